// File: doc/BRIEF.md
# Pipelined Weighted Trigger Condition Evaluator

This block decides, once per clock, whether a set of detector summaries is worth a trigger. Each input set carries a time-of-flight hit count, a forward calorimeter energy, a barrel calorimeter energy and a time stamp. The block forms a weighted score from three terms: a hit term, a forward-energy term and a weighted energy ratio (forward+1)/(barrel+1). It raises a fire bit when the score reaches a programmable threshold. The datapath is fixed point throughout. The ratio comes from a restoring divider that resolves one quotient bit per pipeline stage. A fresh input set is accepted on every clock.

The three weights and the threshold are written into a staging bank while the block runs. A commit strobe moves all four into the working set at once. Every input set takes a snapshot of the working set when it enters, so no result is ever computed with a mix of old and new weights. The time stamp and a valid flag travel with the data, and each result comes out tagged with the stamp of its own inputs after a fixed latency. The block exposes that latency as the localparam `LATENCY`.

Top module: `trig_eq_eval`

## Requirements
- R1: With raw weights A, B, C (unsigned, 8 fraction bits), hit count H and energies Ef, Eb, the ratio is Q = floor(256*(Ef+1)/(Eb+1)). The raw score (8 fraction bits) is Z = A*H + B*Ef + floor(C*Q/256), and it appears on `o_z`.
- R2: `o_fire` is 1 exactly when Z >= T, where T is the raw 32-bit threshold with 8 fraction bits; equality fires.
- R3: If the unsaturated sum is 2^32 or more, `o_z` is 0xFFFFFFFF and `o_fire` is 1 whatever the threshold.
- R4: Each result appears LATENCY = 28 rising edges after the edge that samples its input set. Back-to-back input sets give back-to-back results, and every accepted set yields exactly one result.
- R5: `o_stamp` carries the `in_stamp` value of the input set that produced the result.
- R6: A result is produced only for an input set sampled with `in_valid` = 1. While `o_valid` is 0, `o_fire` and `o_z` are 0.
- R7: A write with `cfg_we` = 1 goes to the staging bank. `cfg_sel` selects the target: 0 is the hit weight A, 1 the forward weight B, 2 the ratio weight C (each from `cfg_data[15:0]`), and 3 the threshold T (all 32 bits). A staged write alone does not change any result.
- R8: On an edge with `cfg_commit` = 1, all four staged values become the working set together, including a write made on that same edge. An input set sampled on that edge uses the old working set, and one sampled on the next edge uses the new set.
- R9: After reset `o_valid` is 0, all weights are 0 and the threshold is 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input set present this cycle |
| in_hits | input | 12 | Time-of-flight hit count |
| in_efwd | input | 16 | Forward calorimeter energy |
| in_ebar | input | 16 | Barrel calorimeter energy |
| in_stamp | input | 16 | Time stamp of the input set |
| cfg_we | input | 1 | Staging write enable |
| cfg_sel | input | 2 | Staging target: 0 A, 1 B, 2 C, 3 threshold |
| cfg_data | input | 32 | Staging write data |
| cfg_commit | input | 1 | Move staged set to working set |
| o_valid | output | 1 | Result present |
| o_fire | output | 1 | Trigger decision |
| o_z | output | 32 | Saturated score, 8 fraction bits |
| o_stamp | output | 16 | Time stamp of the result's input set |

## Verification
Two events can fall on the same edge: a commit of the staged weights and the sampling of an input set. The bench provokes this by raising `cfg_commit` in the very cycle it drives a valid input set. The scoreboard expects that set to use the old weights and the set on the following cycle to use the new ones. A second case stages a new ratio weight and commits it on the same edge. The expected score for the next input must then include that weight, which shows that the commit forwards a same-cycle write.

// File: rtl/trg_pkg.sv
package trg_pkg;

  // staging bank target selector; positions are part of the port contract
  typedef enum logic [1:0] {
    SEL_HIT = 2'd0,
    SEL_FWD = 2'd1,
    SEL_RAT = 2'd2,
    SEL_THR = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/trg_coef_bank.sv
module trg_coef_bank
  import trg_pkg::*;
#(
  parameter int CW = 16,
  parameter int ZW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [ZW-1:0] cfg_data,
  input  logic          cfg_commit,
  output logic [CW-1:0] act_a,
  output logic [CW-1:0] act_b,
  output logic [CW-1:0] act_c,
  output logic [ZW-1:0] act_t
);

  logic [CW-1:0] shd_a, shd_b, shd_c;
  logic [ZW-1:0] shd_t;
  logic [CW-1:0] nx_a, nx_b, nx_c;
  logic [ZW-1:0] nx_t;

  // staged values after this cycle's write (forwarded into a same-cycle commit)
  always_comb begin
    nx_a = shd_a;
    nx_b = shd_b;
    nx_c = shd_c;
    nx_t = shd_t;
    if (cfg_we) begin
      case (cfg_sel)
        SEL_HIT: nx_a = cfg_data[CW-1:0];
        SEL_FWD: nx_b = cfg_data[CW-1:0];
        SEL_RAT: nx_c = cfg_data[CW-1:0];
        SEL_THR: nx_t = cfg_data;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_a <= '0;
      shd_b <= '0;
      shd_c <= '0;
      shd_t <= '1;
      act_a <= '0;
      act_b <= '0;
      act_c <= '0;
      act_t <= '1;
    end else begin
      shd_a <= nx_a;
      shd_b <= nx_b;
      shd_c <= nx_c;
      shd_t <= nx_t;
      if (cfg_commit) begin
        act_a <= nx_a;
        act_b <= nx_b;
        act_c <= nx_c;
        act_t <= nx_t;
      end
    end
  end

  // R8: the working set moves only on a commit
  p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit |=> $stable(act_a) && $stable(act_b) && $stable(act_c) && $stable(act_t));

  // R7: a ratio-weight write lands in the staging bank
  p_stage_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_sel == SEL_RAT |=> shd_c == $past(cfg_data[CW-1:0]));

endmodule

// File: rtl/trg_div_stage.sv
module trg_div_stage #(
  parameter int NW = 17,
  parameter int QW = 25,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [NW-1:0] in_rem,
  input  logic [QW-1:0] in_dq,
  input  logic [NW-1:0] in_den,
  input  logic [PW-1:0] in_pay,
  output logic          out_v,
  output logic [NW-1:0] out_rem,
  output logic [QW-1:0] out_dq,
  output logic [NW-1:0] out_den,
  output logic [PW-1:0] out_pay
);

  // in_dq holds the unconsumed dividend bits on the left, quotient bits on the right
  logic [NW:0]   trial;
  logic [NW-1:0] diff;
  logic          take;

  assign trial = {in_rem, in_dq[QW-1]};
  assign take  = trial >= {1'b0, in_den};
  assign diff  = trial[NW-1:0] - in_den;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v   <= 1'b0;
      out_rem <= '0;
      out_dq  <= '0;
      out_den <= '0;
      out_pay <= '0;
    end else begin
      out_v   <= in_v;
      out_rem <= take ? diff : trial[NW-1:0];
      out_dq  <= {in_dq[QW-2:0], take};
      out_den <= in_den;
      out_pay <= in_pay;
    end
  end

endmodule

// File: rtl/trg_ratio_div.sv
module trg_ratio_div #(
  parameter  int NW = 17,
  parameter  int QF = 8,
  parameter  int PW = 8,
  localparam int QW = NW + QF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_v,
  input  logic [NW-1:0] in_num,
  input  logic [NW-1:0] in_den,
  input  logic [PW-1:0] in_pay,
  output logic          out_v,
  output logic [QW-1:0] out_quo,
  output logic [PW-1:0] out_pay
);

  logic          v_c   [0:QW];
  logic [NW-1:0] rem_c [0:QW];
  logic [QW-1:0] dq_c  [0:QW];
  logic [NW-1:0] den_c [0:QW];
  logic [PW-1:0] pay_c [0:QW];

  assign v_c[0]   = in_v;
  assign rem_c[0] = '0;
  assign dq_c[0]  = {in_num, {QF{1'b0}}};
  assign den_c[0] = in_den;
  assign pay_c[0] = in_pay;

  for (genvar k = 0; k < QW; k++) begin : g_st
    trg_div_stage #(.NW(NW), .QW(QW), .PW(PW)) u_st (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_v    (v_c[k]),
      .in_rem  (rem_c[k]),
      .in_dq   (dq_c[k]),
      .in_den  (den_c[k]),
      .in_pay  (pay_c[k]),
      .out_v   (v_c[k+1]),
      .out_rem (rem_c[k+1]),
      .out_dq  (dq_c[k+1]),
      .out_den (den_c[k+1]),
      .out_pay (pay_c[k+1])
    );
  end

  assign out_v   = v_c[QW];
  assign out_quo = dq_c[QW];
  assign out_pay = pay_c[QW];

  // R1: a finished division leaves a remainder below its divisor
  p_rem_below_div_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_v |-> rem_c[QW] < den_c[QW]);

endmodule

// File: rtl/trig_eq_eval.sv
module trig_eq_eval #(
  parameter int HW  = 12,
  parameter int EW  = 16,
  parameter int CW  = 16,
  parameter int QF  = 8,
  parameter int ZW  = 32,
  parameter int TSW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [HW-1:0]  in_hits,
  input  logic [EW-1:0]  in_efwd,
  input  logic [EW-1:0]  in_ebar,
  input  logic [TSW-1:0] in_stamp,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_sel,
  input  logic [ZW-1:0]  cfg_data,
  input  logic           cfg_commit,
  output logic           o_valid,
  output logic           o_fire,
  output logic [ZW-1:0]  o_z,
  output logic [TSW-1:0] o_stamp
);

  localparam int NW      = EW + 1;
  localparam int QW      = NW + QF;
  localparam int PAW     = CW + HW;
  localparam int PBW     = CW + EW;
  localparam int PSW     = ((PAW > PBW) ? PAW : PBW) + 1;
  localparam int RPW     = CW + QW;
  localparam int RSW     = RPW - QF;
  localparam int SUMW    = ((PSW > RSW) ? PSW : RSW) + 1;
  localparam int PW      = TSW + PSW + CW + ZW;
  localparam int LATENCY = QW + 3;

  function automatic logic [ZW-1:0] clamp_z(input logic [SUMW-1:0] s);
    if (|s[SUMW-1:ZW]) return {ZW{1'b1}};
    return s[ZW-1:0];
  endfunction

  // ---------------- working weights ----------------
  logic [CW-1:0] k_a, k_b, k_c;
  logic [ZW-1:0] k_t;

  trg_coef_bank #(.CW(CW), .ZW(ZW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_data   (cfg_data),
    .cfg_commit (cfg_commit),
    .act_a      (k_a),
    .act_b      (k_b),
    .act_c      (k_c),
    .act_t      (k_t)
  );

  // ---------------- entry stage: data plus weight snapshot ----------------
  logic           s0_v;
  logic [HW-1:0]  s0_h;
  logic [EW-1:0]  s0_ef, s0_eb;
  logic [TSW-1:0] s0_ts;
  logic [CW-1:0]  s0_a, s0_b, s0_c;
  logic [ZW-1:0]  s0_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_v  <= 1'b0;
      s0_h  <= '0;
      s0_ef <= '0;
      s0_eb <= '0;
      s0_ts <= '0;
      s0_a  <= '0;
      s0_b  <= '0;
      s0_c  <= '0;
      s0_t  <= '0;
    end else begin
      s0_v  <= in_valid;
      s0_h  <= in_hits;
      s0_ef <= in_efwd;
      s0_eb <= in_ebar;
      s0_ts <= in_stamp;
      s0_a  <= k_a;
      s0_b  <= k_b;
      s0_c  <= k_c;
      s0_t  <= k_t;
    end
  end

  // linear terms are formed once and ride alongside the divider
  logic [PSW-1:0] part_ab;
  logic [NW-1:0]  div_num, div_den;

  assign part_ab = PSW'(s0_a) * PSW'(s0_h) + PSW'(s0_b) * PSW'(s0_ef);
  assign div_num = NW'(s0_ef) + NW'(1);
  assign div_den = NW'(s0_eb) + NW'(1);

  // ---------------- ratio divider ----------------
  logic           dv_v;
  logic [QW-1:0]  dv_quo;
  logic [PW-1:0]  dv_pay;
  logic [TSW-1:0] dv_ts;
  logic [PSW-1:0] dv_part;
  logic [CW-1:0]  dv_c;
  logic [ZW-1:0]  dv_t;

  trg_ratio_div #(.NW(NW), .QF(QF), .PW(PW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_v    (s0_v),
    .in_num  (div_num),
    .in_den  (div_den),
    .in_pay  ({s0_ts, part_ab, s0_c, s0_t}),
    .out_v   (dv_v),
    .out_quo (dv_quo),
    .out_pay (dv_pay)
  );

  assign {dv_ts, dv_part, dv_c, dv_t} = dv_pay;

  // ---------------- ratio weighting stage ----------------
  logic [RPW-1:0] rat_full;
  logic           m_v;
  logic [TSW-1:0] m_ts;
  logic [PSW-1:0] m_part;
  logic [RSW-1:0] m_rat;
  logic [ZW-1:0]  m_t;

  assign rat_full = RPW'(dv_c) * RPW'(dv_quo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_v    <= 1'b0;
      m_ts   <= '0;
      m_part <= '0;
      m_rat  <= '0;
      m_t    <= '0;
    end else begin
      m_v    <= dv_v;
      m_ts   <= dv_ts;
      m_part <= dv_part;
      m_rat  <= RSW'(rat_full >> QF);
      m_t    <= dv_t;
    end
  end

  // ---------------- sum, clamp and compare ----------------
  logic [SUMW-1:0] sum_w;
  logic            sum_ovf;
  logic [ZW-1:0]   z_sat;

  assign sum_w   = SUMW'(m_part) + SUMW'(m_rat);
  assign sum_ovf = |sum_w[SUMW-1:ZW];
  assign z_sat   = clamp_z(sum_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_fire  <= 1'b0;
      o_z     <= '0;
      o_stamp <= '0;
    end else begin
      o_valid <= m_v;
      o_fire  <= m_v && (z_sat >= m_t);
      o_z     <= m_v ? z_sat : '0;
      o_stamp <= m_ts;
    end
  end

  // R3: an overflowing sum leaves as the top value
  p_ovf_to_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    m_v && sum_ovf |=> o_valid && o_z == {ZW{1'b1}});

  // R3: a saturated score always fires
  p_sat_fires_r3: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid && o_z == {ZW{1'b1}} |-> o_fire);

  // R6: quiet outputs without a result
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !o_valid |-> !o_fire && o_z == '0);

endmodule

// File: tb/sim_trig_eq_eval.sv
module sim_trig_eq_eval;

  localparam int LAT = 28;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [11:0] in_hits;
  logic [15:0] in_efwd, in_ebar, in_stamp;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_data;
  logic        cfg_commit;
  logic        o_valid, o_fire;
  logic [31:0] o_z;
  logic [15:0] o_stamp;

  always #10 clk = ~clk;

  trig_eq_eval u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_hits(in_hits),
    .in_efwd(in_efwd), .in_ebar(in_ebar), .in_stamp(in_stamp),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .cfg_commit(cfg_commit),
    .o_valid(o_valid), .o_fire(o_fire), .o_z(o_z), .o_stamp(o_stamp)
  );

  typedef struct {
    logic [31:0] z;
    logic        fire;
    logic [15:0] ts;
    int          issued;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [15:0] ts_ctr = 16'h0100;

  // bench-side model of the weight banks
  logic [15:0] w_a = 0, w_b = 0, w_c = 0, st_a = 0, st_b = 0, st_c = 0;
  logic [31:0] w_t = 32'hFFFF_FFFF, st_t = 32'hFFFF_FFFF;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic [31:0] score(input logic [15:0] a, b, c, input logic [11:0] h,
                                        input logic [15:0] ef, eb);
    longint unsigned q, tot;
    q   = ((longint'(ef) + 1) * 256) / (longint'(eb) + 1);
    tot = longint'(a) * longint'(h) + longint'(b) * longint'(ef) + (longint'(c) * q) / 256;
    if (tot > 64'hFFFF_FFFF) return 32'hFFFF_FFFF;
    return tot[31:0];
  endfunction

  // one cycle of stimulus, entered and left at a falling edge
  task automatic step(input logic v, input logic [11:0] h, input logic [15:0] ef, eb,
                      input logic we, input logic [1:0] sel, input logic [31:0] d,
                      input logic cm, input string tag);
    exp_t e;
    in_valid = v; in_hits = h; in_efwd = ef; in_ebar = eb; in_stamp = ts_ctr;
    cfg_we = we; cfg_sel = sel; cfg_data = d; cfg_commit = cm;
    if (v) begin
      e.z = score(w_a, w_b, w_c, h, ef, eb);
      e.fire = (e.z >= w_t);
      e.ts = ts_ctr;
      e.issued = cyc;
      e.tag = tag;
      sbq.push_back(e);
      ts_ctr = ts_ctr + 16'd37;
    end
    if (we) begin
      case (sel)
        2'd0: st_a = d[15:0];
        2'd1: st_b = d[15:0];
        2'd2: st_c = d[15:0];
        default: st_t = d;
      endcase
    end
    if (cm) begin
      w_a = st_a; w_b = st_b; w_c = st_c; w_t = st_t;
    end
    @(negedge clk);
    in_valid = 0; cfg_we = 0; cfg_commit = 0;
  endtask

  task automatic drive(input logic [11:0] h, input logic [15:0] ef, eb, input string tag);
    step(1'b1, h, ef, eb, 1'b0, 2'd0, 32'd0, 1'b0, tag);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, input logic cm);
    step(1'b0, 12'd0, 16'd0, 16'd0, 1'b1, sel, d, cm, "cfg");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (o_valid) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R6", "result without input", 1, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(o_z == e.z, e.tag, "R1 score", o_z, e.z);
          check(o_fire == e.fire, e.tag, "R2 fire", o_fire, e.fire);
          check(o_stamp == e.ts, e.tag, "R5 stamp", o_stamp, e.ts);
          check(cyc - e.issued == LAT, e.tag, "R4 latency", cyc - e.issued, LAT);
        end
      end else begin
        check(!o_fire && o_z == 0, "R6", "idle outputs", {o_fire, o_z}, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", "run timed out", cyc, 0);
    finish_run();
  end

  initial begin
    logic [31:0] rs;
    logic [31:0] zb;
    rst_n = 0; in_valid = 0; in_hits = 0; in_efwd = 0; in_ebar = 0; in_stamp = 0;
    cfg_we = 0; cfg_sel = 0; cfg_data = 0; cfg_commit = 0;
    repeat (3) @(negedge clk);
    check(o_valid == 0 && o_fire == 0, "R9", "outputs in reset", {o_valid, o_fire}, 0);
    rst_n = 1;
    @(negedge clk);
    check(o_valid == 0, "R9", "valid after reset", o_valid, 0);

    // R9: reset weights are zero and threshold is the top value
    drive(12'd5, 16'd7, 16'd3, "R9");

    // weights 1.5, 0.25, 2.0 and threshold 256.0
    wr(2'd0, 32'h0180, 1'b0);
    wr(2'd1, 32'h0040, 1'b0);
    wr(2'd2, 32'h0200, 1'b0);
    wr(2'd3, 32'h0001_0000, 1'b1);

    // R1 fixed patterns
    drive(12'd100, 16'd1000, 16'd50, "R1");
    drive(12'd1, 16'd0, 16'hFFFF, "R1");
    drive(12'hFFF, 16'd0, 16'd0, "R1");
    drive(12'd0, 16'hFFFF, 16'd0, "R1");

    // R4 back-to-back stream with R6 bubbles
    rs = 32'h1234_5678;
    for (int i = 0; i < 150; i++) begin
      rs = rs * 32'd1664525 + 32'd1013904223;
      if (i % 7 == 3)
        step(1'b0, rs[11:0], rs[15:0], rs[31:16], 1'b0, 2'd0, 32'd0, 1'b0, "R6");
      else
        drive(rs[27:16], rs[15:0] >> rs[31:28], rs[31:16] >> rs[3:0], "R4");
    end

    // R2 boundary: equal fires, one above does not
    zb = score(w_a, w_b, w_c, 12'd300, 16'd900, 16'd17);
    wr(2'd3, zb, 1'b1);
    drive(12'd300, 16'd900, 16'd17, "R2");
    wr(2'd3, zb + 32'd1, 1'b1);
    drive(12'd300, 16'd900, 16'd17, "R2");

    // R7 staged writes without commit change nothing
    wr(2'd0, 32'hFFFF, 1'b0);
    drive(12'd200, 16'd500, 16'd9, "R7");
    wr(2'd1, 32'h7777, 1'b0);
    drive(12'd200, 16'd500, 16'd9, "R7");

    // R8 commit on the same edge as an input set: old set, then new set
    step(1'b1, 12'd200, 16'd500, 16'd9, 1'b0, 2'd0, 32'd0, 1'b1, "R8");
    drive(12'd200, 16'd500, 16'd9, "R8");
    // R8 write and commit together, forwarded into the working set
    step(1'b1, 12'd40, 16'd300, 16'd2, 1'b1, 2'd2, 32'h0010, 1'b1, "R8");
    drive(12'd40, 16'd300, 16'd2, "R8");

    // R3 overflow saturates and fires against the top threshold
    wr(2'd0, 32'hFFFF, 1'b0);
    wr(2'd1, 32'hFFFF, 1'b0);
    wr(2'd2, 32'hFFFF, 1'b0);
    wr(2'd3, 32'hFFFF_FFFF, 1'b1);
    drive(12'hFFF, 16'hFFFF, 16'd0, "R3");
    drive(12'd1, 16'd0, 16'hFFFF, "R3");
    drive(12'hFFF, 16'hFFFF, 16'hFFFF, "R3");

    repeat (LAT + 5) @(negedge clk);
    check(sbq.size() == 0, "R4", "results outstanding", sbq.size(), 0);
    finish_run();
  end

endmodule